// File: doc/BRIEF.md
# SPI Master on Pins Shared with an I2C Bus

This block drives a memory card in SPI mode while two of its four wires double as the lines of an I2C bus. The card's chip-select line is the I2C clock line, and the SPI data-out line is the I2C data line. The SPI clock and the card's data-return line have pins of their own. The block shifts bytes in SPI mode 0, most significant bit first. It orders every change on the shared pins so that a device on the I2C side never sees its data line fall while its clock line is high, which would be read as a start condition.

Software-side logic issues one of four commands through a valid/busy handshake:
- select the card;
- deselect it;
- exchange one byte;
- run an I2C bus-recovery sequence.

The recovery sequence sends nine clock pulses with the data line released, then a stop condition. Each driven pin is modelled as an output enable plus a level, and a pull-up makes a released line read high. A divider input sets how many system clocks each SPI half-period lasts. The block latches the divider value when it accepts a command.

Top module: `spi_i2c_share_master`

## Requirements
- R1: In reset, all three output enables are 0, all three levels are 1 and busy is 1. In the first cycle after reset is released, the enables are still 0. From the second cycle on, the enables are 1 and busy is 0. An output enable never rises in a cycle in which its level changes.
- R2: A command is accepted in a cycle where cmd_valid is 1 and busy is 0. Command code 0 selects the card and code 1 deselects it. The chip-select level goes to 0 (select) or 1 (deselect) in the cycle after acceptance. Neither command raises busy, and MOSI stays at 1 through both.
- R3: Command code 2 exchanges the byte on cmd_data, most significant bit first. Let D = clk_div + 1. In the cycle after acceptance, SCK goes to 0 and MOSI takes bit 7. SCK then alternates high and low every D cycles for 8 rising edges. busy is 1 for exactly 16·D cycles.
- R4: While chip select is 0, MOSI changes only in a cycle where SCK has just fallen, or in the cycle that ends a byte. In that end-of-byte cycle, MOSI returns to 1 and SCK is 1.
- R5: MISO is sampled at each rising SCK edge. In the cycle after the last high phase, rx_valid is 1 for exactly one cycle and rx_data holds the 8 received bits, the first sampled bit in bit 7.
- R6: A byte-exchange command accepted while the card is deselected has no effect: no pin changes and busy stays 0.
- R7: Whenever chip select is driven high, SCK is driven high.
- R8: The effective data line (1 when released) never falls unless the effective clock line (chip select) was low in both that cycle and the previous one.
- R9: Command code 3, while deselected, runs 21 steps of D cycles each, with busy at 1 throughout:
  - 9 pulses (clock low, then high) with the data line released;
  - a step with the clock low and the data line released;
  - a step with the clock low and the data line driven low;
  - a step with the clock high and the data line low.
  In the next cycle, the data line is driven high and busy is 0.
- R10: A recovery command accepted while the card is selected has no effect on any pin and does not raise busy.
- R11: A command presented while busy is 1 is ignored, and the ongoing sequence continues unchanged.
- R12: Changing clk_div after a command is accepted does not alter that command's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 select, 1 deselect, 2 byte exchange, 3 bus recovery |
| cmd_data | input | DATA_W | Byte to send |
| busy | output | 1 | Command in progress or start-up; new commands are ignored |
| rx_valid | output | 1 | One-cycle pulse when a received byte is ready |
| rx_data | output | DATA_W | Received byte |
| cs_oe | output | 1 | Enable for the chip-select / I2C clock pin |
| cs_lvl | output | 1 | Level for the chip-select / I2C clock pin |
| sck_oe | output | 1 | Enable for the SPI clock pin |
| sck_lvl | output | 1 | Level for the SPI clock pin |
| mosi_oe | output | 1 | Enable for the MOSI / I2C data pin (0 = released) |
| mosi_lvl | output | 1 | Level for the MOSI / I2C data pin |
| miso | input | 1 | Data returned by the card |

## Verification
The properties take a pull-up on both shared lines for granted, so a released line counts as high. They also assume that no other master moves those lines and that the card changes MISO only after a falling SCK edge. The stimulus keeps to these assumptions. Its card model updates MISO only in the cycle after it sees SCK fall, and nothing else in the bench drives the shared lines. Commands are issued only when the model expects the block to be idle, except for deliberate probes during long transfers that test that busy blocks them and that the divider is held.

// File: rtl/spi_i2c_share_pkg.sv
package spi_i2c_share_pkg;

   typedef enum logic [1:0] {
      OP_SELECT   = 2'd0,
      OP_DESELECT = 2'd1,
      OP_XFER     = 2'd2,
      OP_RECOVER  = 2'd3
   } share_op_e;

endpackage

// File: rtl/spi_share_tick.sv
module spi_share_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_q,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || cnt == div_q) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && (cnt == div_q);

endmodule

// File: rtl/spi_share_shifter.sv
module spi_share_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              miso,
   output logic              active,
   output logic              sck,
   output logic              mosi,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte
);

   localparam int PH_N = 2 * DATA_W;
   localparam int PH_W = $clog2(PH_N);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

   logic [PH_W-1:0]   ph;
   logic [DATA_W-1:0] sh_tx;
   logic [DATA_W-1:0] sh_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sck     <= 1'b1;
         mosi    <= 1'b1;
         done    <= 1'b0;
         ph      <= '0;
         sh_tx   <= '0;
         sh_rx   <= '0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            sck    <= 1'b0;
            mosi   <= tx_byte[DATA_W-1];
            sh_tx  <= {tx_byte[DATA_W-2:0], 1'b0};
            ph     <= '0;
         end else if (active && tick) begin
            if (ph == PH_LAST) begin
               active  <= 1'b0;
               sck     <= 1'b1;
               mosi    <= 1'b1;
               done    <= 1'b1;
               rx_byte <= sh_rx;
            end else if (!ph[0]) begin
               sck   <= 1'b1;
               sh_rx <= {sh_rx[DATA_W-2:0], miso};
               ph    <= ph + 1'b1;
            end else begin
               sck   <= 1'b0;
               mosi  <= sh_tx[DATA_W-1];
               sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
               ph    <= ph + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_share_recover.sv
module spi_share_recover #(
   parameter int PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic active,
   output logic scl,
   output logic sda_oe,
   output logic sda_lvl
);

   localparam int STEPS = 2 * PULSES + 3;
   localparam int ST_W  = $clog2(STEPS + 1);
   localparam logic [ST_W-1:0] ST_PULSE_END = ST_W'(2 * PULSES);
   localparam logic [ST_W-1:0] ST_DRIVE     = ST_W'(2 * PULSES + 1);
   localparam logic [ST_W-1:0] ST_LAST      = ST_W'(STEPS - 1);

   logic [ST_W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         st     <= '0;
      end else if (start) begin
         active <= 1'b1;
         st     <= '0;
      end else if (active && tick) begin
         if (st == ST_LAST) begin
            active <= 1'b0;
         end else begin
            st <= st + 1'b1;
         end
      end
   end

   always_comb begin
      if (!active) begin
         scl     = 1'b1;
         sda_oe  = 1'b1;
         sda_lvl = 1'b1;
      end else begin
         scl     = (st < ST_PULSE_END) ? st[0] : (st == ST_LAST);
         sda_oe  = (st >= ST_DRIVE);
         sda_lvl = (st < ST_PULSE_END);
      end
   end

endmodule

// File: rtl/spi_i2c_share_master.sv
module spi_i2c_share_master
   import spi_i2c_share_pkg::*;
#(
   parameter int DIV_W          = 8,
   parameter int DATA_W         = 8,
   parameter int RECOVER_PULSES = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              busy,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              cs_oe,
   output logic              cs_lvl,
   output logic              sck_oe,
   output logic              sck_lvl,
   output logic              mosi_oe,
   output logic              mosi_lvl,
   input  logic              miso
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("DIV_W must be at least 1");
      end
      if (RECOVER_PULSES < 1) begin : g_bad_pulses
         $error("RECOVER_PULSES must be at least 1");
      end
   endgenerate

   share_op_e        op;
   logic             init_done;
   logic             cs_reg;
   logic [DIV_W-1:0] div_q;
   logic             accept;
   logic             x_start;
   logic             r_start;
   logic             tick;
   logic             x_active;
   logic             x_sck;
   logic             x_mosi;
   logic             r_active;
   logic             r_scl;
   logic             r_sda_oe;
   logic             r_sda_lvl;

   assign op      = share_op_e'(cmd_op);
   assign busy    = !init_done || x_active || r_active;
   assign accept  = cmd_valid && !busy;
   assign x_start = accept && (op == OP_XFER) && !cs_reg;
   assign r_start = accept && (op == OP_RECOVER) && cs_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_done <= 1'b0;
         cs_reg    <= 1'b1;
         div_q     <= '0;
      end else begin
         init_done <= 1'b1;
         if (accept) begin
            div_q <= clk_div;
            if (op == OP_SELECT) begin
               cs_reg <= 1'b0;
            end else if (op == OP_DESELECT) begin
               cs_reg <= 1'b1;
            end
         end
      end
   end

   spi_share_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (x_active || r_active),
      .div_q (div_q),
      .tick  (tick)
   );

   spi_share_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (x_start),
      .tx_byte (cmd_data),
      .tick    (tick),
      .miso    (miso),
      .active  (x_active),
      .sck     (x_sck),
      .mosi    (x_mosi),
      .done    (rx_valid),
      .rx_byte (rx_data)
   );

   spi_share_recover #(.PULSES(RECOVER_PULSES)) u_recover (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (r_start),
      .tick    (tick),
      .active  (r_active),
      .scl     (r_scl),
      .sda_oe  (r_sda_oe),
      .sda_lvl (r_sda_lvl)
   );

   assign cs_oe    = init_done;
   assign cs_lvl   = r_active ? r_scl : cs_reg;
   assign sck_oe   = init_done;
   assign sck_lvl  = x_sck;
   assign mosi_oe  = init_done && (r_active ? r_sda_oe : 1'b1);
   assign mosi_lvl = r_active ? r_sda_lvl : x_mosi;

endmodule

// File: rtl/spi_i2c_share_master_chk.sv
module spi_i2c_share_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_oe,
   input logic cs_lvl,
   input logic sck_oe,
   input logic sck_lvl,
   input logic mosi_oe,
   input logic mosi_lvl,
   input logic rx_valid
);

   logic scl_eff;
   logic sda_eff;

   assign scl_eff = !cs_oe || cs_lvl;
   assign sda_eff = !mosi_oe || mosi_lvl;

   // R1
   cs_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_oe) |-> $stable(cs_lvl));

   // R1
   sck_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_oe) |-> $stable(sck_lvl));

   // R1
   mosi_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mosi_oe) |-> $stable(mosi_lvl));

   // R4
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe && !cs_lvl && sck_lvl && $past(sck_lvl) && mosi_oe && $past(mosi_oe) && !rx_valid)
      |-> $stable(mosi_lvl));

   // R5
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe && cs_lvl) |-> (sck_oe && sck_lvl));

   // R8
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_eff) |-> (!scl_eff && !$past(scl_eff)));

endmodule

bind spi_i2c_share_master spi_i2c_share_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_oe    (cs_oe),
   .cs_lvl   (cs_lvl),
   .sck_oe   (sck_oe),
   .sck_lvl  (sck_lvl),
   .mosi_oe  (mosi_oe),
   .mosi_lvl (mosi_lvl),
   .rx_valid (rx_valid)
);

// File: tb/spi_i2c_share_master_tb.sv
`timescale 1ns/1ps
module spi_i2c_share_master_tb;

   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] clk_div = '0;
   logic             cmd_valid = 1'b0;
   logic [1:0]       cmd_op = 2'd0;
   logic [7:0]       cmd_data = 8'h00;
   logic             busy, rx_valid;
   logic [7:0]       rx_data;
   logic             cs_oe, cs_lvl, sck_oe, sck_lvl, mosi_oe, mosi_lvl;
   logic             miso = 1'b1;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    cmp_en = 1'b0;
   bit    finished = 1'b0;
   string cur_req = "R1";
   logic [7:0] q[$];
   logic [7:0] idle_v;
   logic [7:0] exp_rx = 8'h00;
   logic [7:0] slave_byte = 8'hFF;
   int    sidx = 0;
   logic  sck_prev = 1'b1;

   always #10 clk = ~clk;

   spi_i2c_share_master #(.DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .rx_valid(rx_valid),
      .rx_data(rx_data), .cs_oe(cs_oe), .cs_lvl(cs_lvl), .sck_oe(sck_oe),
      .sck_lvl(sck_lvl), .mosi_oe(mosi_oe), .mosi_lvl(mosi_lvl), .miso(miso)
   );

   // vector: busy, cs_oe, cs, sck_oe, sck, mosi_oe, mosi, rx_valid
   function automatic logic [7:0] mk(input logic b, input logic cs, input logic sck,
                                     input logic moe, input logic mo, input logic rv);
      return {b, 1'b1, cs, 1'b1, sck, moe, mo, rv};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   // card model: new MISO bit right after each falling SCK edge
   always @(negedge clk) begin
      if (sck_prev && !sck_lvl) begin
         miso <= slave_byte[7-sidx];
         sidx <= sidx + 1;
      end
      sck_prev <= sck_lvl;
   end

   // per-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (cmp_en) begin
         logic [7:0] e;
         e = (q.size() > 0) ? q.pop_front() : idle_v;
         check(cur_req, {busy, cs_oe, cs_lvl, sck_oe, sck_lvl, mosi_oe, mosi_lvl, rx_valid}, e);
         if (e[0]) check({cur_req, " rx byte R5"}, rx_data, exp_rx);
      end
   end

   task automatic wait_idle();
      while (q.size() != 0) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [7:0] d, input int div);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d; clk_div = DIV_W'(div);
      q.push_back(idle_v);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic do_sel(input bit sel);
      wait_idle();
      cur_req = "R2";
      q.push_back(idle_v);
      idle_v = mk(0, !sel, 1, 1, 1, 0);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = sel ? 2'd0 : 2'd1;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   // byte exchange while selected: R3 R4 R5 R7 R8
   task automatic do_xfer(input logic [7:0] tx, input logic [7:0] sb, input int div);
      int d;
      wait_idle();
      cur_req = "R3/R4/R5/R7/R8";
      d = div + 1;
      slave_byte = sb; sidx = 0; exp_rx = sb;
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = tx; clk_div = DIV_W'(div);
      q.push_back(idle_v);
      for (int i = 0; i < 8; i++) begin
         for (int k = 0; k < d; k++) q.push_back(mk(1, 0, 0, 1, tx[7-i], 0));
         for (int k = 0; k < d; k++) q.push_back(mk(1, 0, 1, 1, tx[7-i], 0));
      end
      q.push_back(mk(0, 0, 1, 1, 1, 1));
      idle_v = mk(0, 0, 1, 1, 1, 0);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   // bus recovery while deselected: R9 R8 R7
   task automatic do_recover(input int div);
      int d;
      wait_idle();
      cur_req = "R9/R8";
      d = div + 1;
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = 2'd3; clk_div = DIV_W'(div);
      q.push_back(idle_v);
      for (int st = 0; st < 21; st++) begin
         logic scl, oe, lv;
         scl = (st < 18) ? st[0] : (st == 20);
         oe  = (st >= 19);
         lv  = (st < 18);
         for (int k = 0; k < d; k++) q.push_back(mk(1, scl, 1, oe, lv, 0));
      end
      idle_v = mk(0, 1, 1, 1, 1, 0);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      wait_idle();
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      idle_v = mk(0, 1, 1, 1, 1, 0);
      // R1: state while in reset
      repeat (3) @(negedge clk);
      check("R1 reset", {busy, cs_oe, cs_lvl, sck_oe, sck_lvl, mosi_oe, mosi_lvl, rx_valid}, 8'b1010_1010);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first cycle after release, drivers still off, levels high
      check("R1 preset", {busy, cs_oe, cs_lvl, sck_oe, sck_lvl, mosi_oe, mosi_lvl, rx_valid}, 8'b1010_1010);
      @(negedge clk);
      check("R1 enable", {busy, cs_oe, cs_lvl, sck_oe, sck_lvl, mosi_oe, mosi_lvl, rx_valid}, 8'b0111_1110);
      #1;
      cmp_en = 1'b1;

      // R6: byte exchange while deselected is ignored
      cur_req = "R6";
      issue(2'd2, 8'h00, 0);
      idle_cycles(6);

      do_recover(1);
      idle_cycles(3);

      do_sel(1'b1);
      idle_cycles(2);

      // R10: recovery while selected is ignored
      cur_req = "R10";
      issue(2'd3, 8'h00, 0);
      idle_cycles(5);

      do_xfer(8'hA5, 8'h3C, 0);
      do_xfer(8'h00, 8'hFF, 2);
      // R11 R12: deselect and divider change during the transfer are ignored
      @(posedge clk); #1;
      cur_req = "R11/R12";
      cmd_valid = 1'b1; cmd_op = 2'd1; clk_div = '0;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      do_xfer(8'hFF, 8'h81, 1);
      do_xfer(8'h6E, 8'h00, 3);
      idle_cycles(3);

      do_sel(1'b0);
      idle_cycles(3);
      do_recover(0);
      idle_cycles(5);
      finish_run();
   end

endmodule